// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Code Register

This block is the digital front end of a four-channel digital-to-analog converter. A host presents a channel address, a data word and a gain bit, asserts an active-low select and pulses an active-low write strobe. On the strobe's rising edge the word goes into the addressed channel's first-rank (staging) register. A separate active-low transfer strobe moves staged values into the second-rank (output) registers, whose contents drive the four converters. This lets several channels change output at the same instant.

The transfer strobe works in two ways. If it is pulsed low between writes, every output register takes its staged value on the same cycle. If it is held low across a write, the block becomes transparent and the written word reaches its output register in the same cycle as it reaches the staging register. An asynchronous clear and the power-on reset force every register to zero. An active-low power-down pin puts all four channels into power-down and keeps the register contents.

All pins are sampled by two-flop synchronizers in the system clock domain. The clock period must therefore be well below the shortest strobe pulse. Codes are straight binary, from 0 to 2^N-1, with N set by a parameter.

Top module: `quad_dac_regif`

## Requirements
- R1: After reset, all four codes are 0, gain_x2 is 0 (gain 1), and pwr_down follows the pd_n pin.
- R2: A write needs cs_n low while wr_n rises. It loads the data word into the staging register of the channel selected by addr, where addr[1] is the MSB: 0 selects A, 1 selects B, 2 selects C and 3 selects D. No other channel's staging register changes.
- R3: A wr_n rising edge while cs_n is high has no effect. A later transfer shows the old values.
- R4: While ldac_n is high, writes do not change any code output or gain_x2.
- R5: A low pulse on ldac_n outside a write copies all four staging registers, plus the staged gain bit, to the outputs on the same cycle.
- R6: With ldac_n held low across a write, the written channel's code output shows the new word within 4 clock cycles of the wr_n rising edge.
- R7: While ldac_n stays low, every output register equals its staging register from the next cycle onward.
- R8: A low clr_n zeros every staging register, every output register and gain_x2 at once, with no clock edge needed. A write whose strobe edge falls inside the clear is lost.
- R9: While pd_n is low, pwr_down is 1, the codes keep their values and writes are ignored. pwr_down returns to 0 after pd_n returns high.
- R10: gain_sel is captured with each accepted write and reaches gain_x2 on transfer. gain_sel = 0 gives gain_x2 = 0 (gain 1) and gain_sel = 1 gives gain_x2 = 1 (gain 2).
- R11: The full-scale code 2^N-1 and the code 0 both pass through to the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the synchronizers and registers |
| rst_n | input | 1 | Active-low power-on reset, asserted asynchronously and released synchronously |
| cs_n | input | 1 | Active-low select; a write counts only while it is low |
| wr_n | input | 1 | Active-low write strobe; data is captured on its rising edge |
| addr | input | 2 | Channel address, with bit 1 as the MSB (0=A, 1=B, 2=C, 3=D) |
| data | input | N | Code word to stage |
| gain_sel | input | 1 | Gain bit captured with the data (0: gain 1, 1: gain 2) |
| ldac_n | input | 1 | Active-low transfer strobe from the staging rank to the output rank |
| clr_n | input | 1 | Asynchronous active-low clear of both register ranks |
| pd_n | input | 1 | Active-low power-down for all channels |
| code_a | output | N | Output code of channel A |
| code_b | output | N | Output code of channel B |
| code_c | output | N | Output code of channel C |
| code_d | output | N | Output code of channel D |
| gain_x2 | output | 1 | Applied gain: 1 selects gain 2 |
| pwr_down | output | 1 | High while all channels are powered down |

## Verification
The bench targets cases where the two register ranks could be confused. If the block lost the separation, a write with the transfer strobe high would move an output early. If transparent mode used the old staged value, a synchronous-mode write would show the previous code. Writes with select high and writes during power-down must leave no trace after a later transfer. A leak there would show up as a changed code. The clear is checked before any clock edge follows it and with a write strobe edge inside it, which catches a clear that waits for the clock or lets the write through. Alternating gain bits and the code words 0, 2^N-1 and the mid-scale boundary catch a dropped gain capture or a truncated data bit.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int ADDR_W = 2;
  localparam int NCH    = 1 << ADDR_W;
  // control pins carried through the synchronizer: select, write, transfer, power-down
  localparam int CTRL_W = 4;
endpackage

// File: rtl/dacif_sync.sv
// Two-flop synchronizer with a selectable reset value per bit.
module dacif_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dacif_edge.sv
// Rising-edge detector on an already synchronized level.
module dacif_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= IDLE;
    else        dly_q <= sig;
  end

  assign rise = sig & ~dly_q;
endmodule

// File: rtl/dacif_chan_reg.sv
// One channel: staging rank followed by output rank.
module dacif_chan_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         xfer,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] out_q
);
  logic [W-1:0] stage_nxt;
  logic [W-1:0] out_nxt;

  always_comb begin
    stage_nxt = stage_q;
    if (we) stage_nxt = wdata;
    out_nxt = out_q;
    // forward the write so transparent mode shows it on the same edge
    if (xfer) out_nxt = stage_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      stage_q <= stage_nxt;
      out_q   <= out_nxt;
    end
  end
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import dacif_pkg::*;
#(
  parameter int N = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      data,
  input  logic              gain_sel,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              pd_n,
  output logic [N-1:0]      code_a,
  output logic [N-1:0]      code_b,
  output logic [N-1:0]      code_c,
  output logic [N-1:0]      code_d,
  output logic              gain_x2,
  output logic              pwr_down
);
  localparam int SYNC_W = CTRL_W + ADDR_W + N + 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{CTRL_W{1'b1}}, {(SYNC_W-CTRL_W){1'b0}}};

  // reset trees: pins use the plain reset, the register ranks also take the clear
  logic sys_rst_n;
  logic reg_rst_n;
  logic clr_arst_n;

  assign clr_arst_n = rst_n & clr_n;

  dacif_sync #(.W(1), .RST_VAL(1'b0)) u_sys_rst (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(sys_rst_n)
  );

  dacif_sync #(.W(1), .RST_VAL(1'b0)) u_reg_rst (
    .clk(clk), .arst_n(clr_arst_n), .d(1'b1), .q(reg_rst_n)
  );

  // pin synchronization
  logic [SYNC_W-1:0] pins_raw;
  logic [SYNC_W-1:0] pins_s;
  logic              cs_s, wr_s, ldac_s, pd_s, gain_s;
  logic [ADDR_W-1:0] addr_s;
  logic [N-1:0]      data_s;

  assign pins_raw = {cs_n, wr_n, ldac_n, pd_n, addr, data, gain_sel};

  dacif_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_pin_sync (
    .clk(clk), .arst_n(sys_rst_n), .d(pins_raw), .q(pins_s)
  );

  assign {cs_s, wr_s, ldac_s, pd_s, addr_s, data_s, gain_s} = pins_s;

  // write strobe edge and accept qualification
  logic wr_rise;
  logic wr_acc;
  logic xfer;

  dacif_edge #(.IDLE(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(sys_rst_n), .sig(wr_s), .rise(wr_rise)
  );

  assign wr_acc = wr_rise & ~cs_s & pd_s;
  assign xfer   = ~ldac_s;

  // channel ranks
  logic [NCH*N-1:0] in_flat;
  logic [NCH*N-1:0] dac_flat;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic ch_we;
    assign ch_we = wr_acc && (addr_s == ADDR_W'(ch));

    dacif_chan_reg #(.W(N)) u_chan (
      .clk     (clk),
      .rst_n   (reg_rst_n),
      .we      (ch_we),
      .wdata   (data_s),
      .xfer    (xfer),
      .stage_q (in_flat[ch*N +: N]),
      .out_q   (dac_flat[ch*N +: N])
    );
  end

  // gain bit shares the two-rank structure, written on every accepted write
  logic gain_stage;

  dacif_chan_reg #(.W(1)) u_gain (
    .clk     (clk),
    .rst_n   (reg_rst_n),
    .we      (wr_acc),
    .wdata   (gain_s),
    .xfer    (xfer),
    .stage_q (gain_stage),
    .out_q   (gain_x2)
  );

  assign code_a   = dac_flat[0*N +: N];
  assign code_b   = dac_flat[1*N +: N];
  assign code_c   = dac_flat[2*N +: N];
  assign code_d   = dac_flat[3*N +: N];
  assign pwr_down = ~pd_s;
endmodule

// File: rtl/quad_dac_regif_chk.sv
module quad_dac_regif_chk #(
  parameter int N   = 12,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_n,
  input logic           ld_s,
  input logic           pd_s,
  input logic           gain_out,
  input logic [NCH*N-1:0] in_flat,
  input logic [NCH*N-1:0] dac_flat
);
  logic [NCH*N-1:0] in_prev_q;
  logic [NCH-1:0]   chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_prev_q <= '0;
    else        in_prev_q <= in_flat;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      chg[i] = (in_flat[i*N +: N] != in_prev_q[i*N +: N]);
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_flat == '0 && in_flat == '0 && !gain_out));

  // R4
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    ld_s |=> ($stable(dac_flat) && $stable(gain_out)));

  // R7
  transparent_track_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !ld_s |=> (dac_flat == in_flat));

  // R9
  pd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !pd_s |=> $stable(in_flat));

  // R2
  single_channel_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    $countones(chg) <= 1);
endmodule

bind quad_dac_regif quad_dac_regif_chk #(.N(N), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .ld_s     (ldac_s),
  .pd_s     (pd_s),
  .gain_out (gain_x2),
  .in_flat  (in_flat),
  .dac_flat (dac_flat)
);

// File: tb/tb_quad_dac_regif.sv
module tb_quad_dac_regif;
  localparam int N = 12;

  logic         clk;
  logic         rst_n;
  logic         cs_n, wr_n, ldac_n, clr_n, pd_n, gain_sel;
  logic [1:0]   addr;
  logic [N-1:0] data;
  logic [N-1:0] code_a, code_b, code_c, code_d;
  logic         gain_x2, pwr_down;

  quad_dac_regif #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .data(data), .gain_sel(gain_sel), .ldac_n(ldac_n), .clr_n(clr_n),
    .pd_n(pd_n), .code_a(code_a), .code_b(code_b), .code_c(code_c),
    .code_d(code_d), .gain_x2(gain_x2), .pwr_down(pwr_down)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of both ranks
  logic [N-1:0] in_m  [4];
  logic [N-1:0] dac_m [4];
  logic         gin_m, gout_m;
  logic         pd_m;

  // {sync_mode, cs_active, addr[1:0], gain, data[11:0]}
  localparam logic [16:0] VEC [10] = '{
    {1'b0, 1'b1, 2'd0, 1'b0, 12'h123},
    {1'b0, 1'b1, 2'd1, 1'b1, 12'hFFF},
    {1'b0, 1'b1, 2'd2, 1'b0, 12'h800},
    {1'b0, 1'b1, 2'd3, 1'b1, 12'h001},
    {1'b0, 1'b0, 2'd0, 1'b1, 12'hABC},
    {1'b1, 1'b1, 2'd1, 1'b0, 12'h5A5},
    {1'b1, 1'b1, 2'd3, 1'b1, 12'h000},
    {1'b0, 1'b1, 2'd2, 1'b1, 12'h7FF},
    {1'b1, 1'b1, 2'd0, 1'b0, 12'hFFF},
    {1'b0, 1'b1, 2'd3, 1'b0, 12'h3C3}
  };

  function automatic logic [N-1:0] code_of(int i);
    case (i)
      0: return code_a;
      1: return code_b;
      2: return code_c;
      default: return code_d;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 4; i++) chk(tag, 32'(code_of(i)), 32'(dac_m[i]));
    chk(tag, 32'(gain_x2), 32'(gout_m));
  endtask

  task automatic model_xfer();
    for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
    gout_m = gin_m;
  endtask

  task automatic do_write(logic [1:0] a, logic [N-1:0] d, logic g, logic cs_act, logic hold_ld);
    @(negedge clk);
    cs_n = ~cs_act; addr = a; data = d; gain_sel = g;
    if (hold_ld) ldac_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    if (cs_act && !pd_m) begin
      in_m[a] = d;
      gin_m   = g;
    end
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    if (hold_ld) begin
      model_xfer();
      ldac_n = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ldac();
    @(negedge clk);
    ldac_n = 1'b0;
    repeat (3) @(negedge clk);
    ldac_n = 1'b1;
    model_xfer();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ldac_n = 1'b1; clr_n = 1'b1;
    pd_n = 1'b1; gain_sel = 1'b0; addr = '0; data = '0;
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; dac_m[i] = '0; end
    gin_m = 1'b0; gout_m = 1'b0; pd_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1 reset state
    check_all("R1 reset codes");
    chk("R1 pwr_down after reset", 32'(pwr_down), 32'd0);

    // vector walk: R2 R3 R4 R5 R6 R10 R11
    for (int k = 0; k < 10; k++) begin
      logic [16:0] v;
      v = VEC[k];
      do_write(v[14:13], v[11:0], v[12], v[15], v[16]);
      if (v[16]) begin
        check_all("R6 sync write passes through");
      end else begin
        check_all("R4 outputs held before transfer");
        pulse_ldac();
        check_all(v[15] ? "R5 R2 R10 R11 transfer" : "R3 unselected write ignored");
      end
    end

    // R7 transparent while ldac_n low
    @(negedge clk);
    ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    model_xfer();
    do_write(2'd2, 12'h0F0, 1'b1, 1'b1, 1'b0);
    model_xfer();
    check_all("R7 transparent first");
    do_write(2'd1, 12'hE01, 1'b0, 1'b1, 1'b0);
    model_xfer();
    check_all("R7 transparent second");
    @(negedge clk);
    ldac_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 power-down keeps codes, blocks writes
    pd_n = 1'b0; pd_m = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 pwr_down asserted", 32'(pwr_down), 32'd1);
    check_all("R9 codes kept in power-down");
    do_write(2'd0, 12'h444, 1'b1, 1'b1, 1'b0);
    pulse_ldac();
    check_all("R9 write ignored in power-down");
    pd_n = 1'b1; pd_m = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 pwr_down released", 32'(pwr_down), 32'd0);
    check_all("R9 codes after release");

    // R8 asynchronous clear, with a write edge inside it
    do_write(2'd3, 12'hBEE, 1'b1, 1'b1, 1'b1);
    check_all("R8 preload");
    @(negedge clk);
    cs_n = 1'b0; addr = 2'd1; data = 12'h999; gain_sel = 1'b1; wr_n = 1'b0;
    #2;
    clr_n = 1'b0;
    #1;
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; dac_m[i] = '0; end
    gin_m = 1'b0; gout_m = 1'b0;
    check_all("R8 clear without clock edge");
    @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R8 codes after clear");
    pulse_ldac();
    check_all("R8 staging cleared and write lost");

    finish_run();
  end
endmodule